// File: doc/BRIEF.md
# One-Time-Programmable Byte Array Controller

This block sits behind a simple register port and gives a host byte-wide access to an array of one-time-programmable storage. The host takes the array out of power-down, loads a byte address split across a low and a high register, chooses a read or a program in the function register, and writes the go bit. The controller checks the request. It then holds a busy flag for a fixed number of cycles and performs the access. It reports the outcome in a result register. A read also returns the stored byte in a read-data register.

The storage is modelled so that programming can only turn bits on. A program merges the requested byte into the stored byte with a bitwise OR. The controller then compares the merged value with the request and flags a failure whenever they differ. When a request cannot run at all, the controller flags a failure in the same cycle and never raises busy. This covers a powered-down array, a program without byte mode, an ambiguous function selection, and an address beyond the modelled storage. The modelled storage holds `ARRAY_BYTES` bytes (2048 by default), while the address registers always carry a 13-bit byte address. The storage is blank (all zero) after reset.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, offset 0x00 (power-down, bit 0) reads 1 and every other register reads 0: status at 0x30, result at 0x2C, read data at 0x18, function at 0x20, go at 0x28, address low at 0x08 and address high at 0x04.
- R2: The 13-bit byte address is formed from the address-low register at 0x08 (address bits 7:0, register bits 7:0) and the address-high register at 0x04 (address bits 12:8, register bits 4:0). Unused register bits read back as 0.
- R3: A read starts when 1 is written to bit 0 at 0x28, with function 0x20 equal to 1 (bit 0 = read). Status bit 0 at 0x30 then reads 1 for exactly `BUSY_CYCLES` cycles, starting the cycle after the go write. On completion, bits 7:0 at 0x18 hold the stored byte and result bit 0 at 0x2C is 0.
- R4: A program runs with function 0x20 equal to 2 (bit 1 = program), byte mode (bit 0 at 0x14) set, and the data in bits 7:0 at 0x10. It stores the OR of the old byte and the data. The result bit reads 0 when the stored byte then equals the data.
- R5: A program whose data would need a stored 1 cleared still stores the OR of the old byte and the data, and sets result bit 0 to 1.
- R6: Writing go while power-down bit 0 is 1 never raises busy, leaves the storage untouched, and sets result bit 0 to 1 in the same cycle.
- R7: Writing go for a program while byte mode is 0 never raises busy, leaves the stored byte unchanged, and sets result bit 0 to 1.
- R8: Writing go when the function value is 0 or 3 never raises busy and sets result bit 0 to 1.
- R9: Writing go with an address at or above `ARRAY_BYTES` never raises busy and sets result bit 0 to 1.
- R10: Go bit 0 reads 1 while busy. When an operation completes or is refused, both the go bit and the function register read 0.
- R11: Register writes made while busy is 1 are ignored.
- R12: Writing the go register with bit 0 at 0 starts nothing and leaves the function register and the result bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port, one cycle per write |
| reg_addr | input | 8 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The checker assumes the host never changes the operation's inputs while busy. These inputs are the address, the program data, the byte mode, the function and power-down. The design enforces this by dropping such writes, and the bench drives a write mid-operation to confirm it. The checker also assumes that busy only starts from a go write. The bench therefore polls status until it clears before it issues the next request. Every register access is a single-cycle strobe applied away from the clock edge.

// File: rtl/otp_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the one-time-programmable array controller.
// Assumes an 8-bit register offset space; offsets below are decoded by the register file.
package otp_ctrl_pkg;

    localparam int OTP_ADDR_W = 13;

    localparam logic [7:0] OFS_PWR    = 8'h00;
    localparam logic [7:0] OFS_AHI    = 8'h04;
    localparam logic [7:0] OFS_ALO    = 8'h08;
    localparam logic [7:0] OFS_PDATA  = 8'h10;
    localparam logic [7:0] OFS_PMODE  = 8'h14;
    localparam logic [7:0] OFS_RDATA  = 8'h18;
    localparam logic [7:0] OFS_FUNC   = 8'h20;
    localparam logic [7:0] OFS_GO     = 8'h28;
    localparam logic [7:0] OFS_RESULT = 8'h2C;
    localparam logic [7:0] OFS_STAT   = 8'h30;

    typedef enum logic [1:0] {
        FN_NONE = 2'b00,
        FN_READ = 2'b01,
        FN_PROG = 2'b10,
        FN_BOTH = 2'b11
    } otp_fn_e;

endpackage

// File: rtl/otp_array.sv
`timescale 1ns/1ps
// Module: otp_array
// Behavioural model of the byte array. It reads combinationally and writes synchronously.
// Assumes the sequencer only ever writes old|new, so bits are never cleared here.
// The model starts blank at reset, which stands in for an unprogrammed part.
module otp_array #(
    parameter int ARRAY_BYTES = 2048,
    localparam int IDX_W = $clog2(ARRAY_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] cells [ARRAY_BYTES];

    // Purpose: blank the storage on reset and commit merged bytes on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_BYTES; i++) begin
                cells[i] <= 8'h00;
            end
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    // Purpose: present the addressed byte.
    always_comb begin
        rdata = cells[idx];
    end

endmodule

// File: rtl/otp_seq.sv
`timescale 1ns/1ps
// Module: otp_seq
// Checks each go request, runs accepted operations for BUSY_CYCLES cycles, and records
// the outcome. Assumes its operand inputs stay stable while busy, which the register
// file enforces.
module otp_seq
    import otp_ctrl_pkg::*;
#(
    parameter int ADDR_W      = OTP_ADDR_W,
    parameter int ARRAY_BYTES = 2048,
    parameter int BUSY_CYCLES = 4,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic [1:0]        func,
    input  logic              pwr_dn,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        pgm_byte,
    input  logic [7:0]        arr_rdata,
    output logic              busy,
    output logic              fail,
    output logic [7:0]        rd_byte,
    output logic              func_clr,
    output logic              arr_we,
    output logic [7:0]        arr_wdata
);

    logic             reject;
    logic             finish;
    logic             is_prog_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: decide whether a go request is refused without starting.
    always_comb begin
        reject = pwr_dn
              || !(func == FN_READ || func == FN_PROG)
              || (func == FN_PROG && !byte_mode)
              || (32'(op_addr) >= ARRAY_BYTES);
    end

    // Purpose: derive completion, function clearing and the merged write value.
    always_comb begin
        finish    = busy && (cnt_q == '0);
        func_clr  = (go_req && reject) || finish;
        arr_wdata = arr_rdata | pgm_byte;
        arr_we    = finish && is_prog_q;
    end

    // Purpose: run the busy window and capture the result of each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt_q     <= '0;
            is_prog_q <= 1'b0;
            fail      <= 1'b0;
            rd_byte   <= 8'h00;
        end else if (go_req) begin
            if (reject) begin
                fail <= 1'b1;
            end else begin
                busy      <= 1'b1;
                cnt_q     <= CNT_W'(BUSY_CYCLES - 1);
                is_prog_q <= (func == FN_PROG);
            end
        end else if (finish) begin
            busy <= 1'b0;
            if (is_prog_q) begin
                fail <= (arr_wdata != pgm_byte);
            end else begin
                rd_byte <= arr_rdata;
                fail    <= 1'b0;
            end
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/otp_regfile.sv
`timescale 1ns/1ps
// Module: otp_regfile
// Host-visible register file with the write decode, the go strobe and the read mux.
// Assumes single-cycle write strobes. It ignores every write while the sequencer is busy.
module otp_regfile
    import otp_ctrl_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = OTP_ADDR_W,
    localparam int HI_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              fail,
    input  logic [7:0]        rd_byte,
    input  logic              func_clr,
    output logic              pwr_dn,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        pgm_byte,
    output logic              byte_mode,
    output logic [1:0]        func,
    output logic              go_req
);

    logic            wr_ok;
    logic [7:0]      addr_lo_q;
    logic [HI_W-1:0] addr_hi_q;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:8];

    // Purpose: qualify host writes and form the go strobe.
    always_comb begin
        wr_ok   = reg_wr && !busy;
        go_req  = wr_ok && (reg_addr == REG_AW'(OFS_GO)) && reg_wdata[0];
        op_addr = {addr_hi_q, addr_lo_q};
    end

    // Purpose: hold the host-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_dn    <= 1'b1;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            pgm_byte  <= '0;
            byte_mode <= 1'b0;
            func      <= '0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    REG_AW'(OFS_PWR):   pwr_dn    <= reg_wdata[0];
                    REG_AW'(OFS_ALO):   addr_lo_q <= reg_wdata[7:0];
                    REG_AW'(OFS_AHI):   addr_hi_q <= reg_wdata[HI_W-1:0];
                    REG_AW'(OFS_PDATA): pgm_byte  <= reg_wdata[7:0];
                    REG_AW'(OFS_PMODE): byte_mode <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (func_clr) begin
                func <= '0;
            end else if (wr_ok && reg_addr == REG_AW'(OFS_FUNC)) begin
                func <= reg_wdata[1:0];
            end
        end
    end

    // Purpose: return the addressed register, zero-extended; unmapped offsets read 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(OFS_PWR):    reg_rdata[0]        = pwr_dn;
            REG_AW'(OFS_ALO):    reg_rdata[7:0]      = addr_lo_q;
            REG_AW'(OFS_AHI):    reg_rdata[HI_W-1:0] = addr_hi_q;
            REG_AW'(OFS_PDATA):  reg_rdata[7:0]      = pgm_byte;
            REG_AW'(OFS_PMODE):  reg_rdata[0]        = byte_mode;
            REG_AW'(OFS_RDATA):  reg_rdata[7:0]      = rd_byte;
            REG_AW'(OFS_FUNC):   reg_rdata[1:0]      = func;
            REG_AW'(OFS_GO):     reg_rdata[0]        = busy;
            REG_AW'(OFS_RESULT): reg_rdata[0]        = fail;
            REG_AW'(OFS_STAT):   reg_rdata[0]        = busy;
            default: ;
        endcase
    end

endmodule

// File: rtl/otp_prog_ctrl.sv
`timescale 1ns/1ps
// Module: otp_prog_ctrl
// Top level of the controller. It joins the register file, the sequencer and the array
// model. Assumes a single host with single-cycle register strobes.
module otp_prog_ctrl
    import otp_ctrl_pkg::*;
#(
    parameter int REG_AW      = 8,
    parameter int DATA_W      = 32,
    parameter int ARRAY_BYTES = 2048,
    parameter int BUSY_CYCLES = 4,
    localparam int ADDR_W = OTP_ADDR_W,
    localparam int IDX_W  = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    logic              busy;
    logic              fail;
    logic [7:0]        rd_byte;
    logic              func_clr;
    logic              pwr_dn;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        pgm_byte;
    logic              byte_mode;
    logic [1:0]        func;
    logic              go_req;
    logic              arr_we;
    logic [7:0]        arr_wdata;
    logic [7:0]        arr_rdata;

    otp_regfile #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .fail      (fail),
        .rd_byte   (rd_byte),
        .func_clr  (func_clr),
        .pwr_dn    (pwr_dn),
        .op_addr   (op_addr),
        .pgm_byte  (pgm_byte),
        .byte_mode (byte_mode),
        .func      (func),
        .go_req    (go_req)
    );

    otp_seq #(
        .ADDR_W      (ADDR_W),
        .ARRAY_BYTES (ARRAY_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_req    (go_req),
        .func      (func),
        .pwr_dn    (pwr_dn),
        .byte_mode (byte_mode),
        .op_addr   (op_addr),
        .pgm_byte  (pgm_byte),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .fail      (fail),
        .rd_byte   (rd_byte),
        .func_clr  (func_clr),
        .arr_we    (arr_we),
        .arr_wdata (arr_wdata)
    );

    otp_array #(
        .ARRAY_BYTES (ARRAY_BYTES)
    ) array_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .idx   (op_addr[IDX_W-1:0]),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/otp_prog_ctrl_chk.sv
`timescale 1ns/1ps
// Module: otp_prog_ctrl_chk
// Property checker bound into otp_prog_ctrl. It watches the busy window, the function
// clearing, operand stability and the set-only write rule.
module otp_prog_ctrl_chk #(
    parameter int BUSY_CYCLES = 4,
    parameter int ADDR_W      = 13,
    localparam int RUN_W = $clog2(BUSY_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              pwr_dn,
    input logic [1:0]        func,
    input logic [ADDR_W-1:0] op_addr,
    input logic              arr_we,
    input logic [7:0]        arr_wdata,
    input logic [7:0]        arr_rdata
);

    logic [RUN_W-1:0] run_len;

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == RUN_W'(BUSY_CYCLES));

    // R5
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ((arr_wdata & arr_rdata) == arr_rdata));

    // R4
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R10
    func_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> func == 2'b00);

    // R6
    no_start_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !pwr_dn);

    // R11
    stable_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_addr));

endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .ADDR_W      (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pwr_dn    (pwr_dn),
    .func      (func),
    .op_addr   (op_addr),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata),
    .arr_rdata (arr_rdata)
);

// File: tb/otp_prog_ctrl_test.sv
`timescale 1ns/1ps
module otp_prog_ctrl_test;

    localparam int BUSY = 4;
    localparam int ABYTES = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    otp_prog_ctrl #(.ARRAY_BYTES(ABYTES), .BUSY_CYCLES(BUSY)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Entry: [31:30] op (1 read, 2 program), [29:17] address, [16:9] data,
    // [8:1] expected read byte, [0] expected result bit
    localparam int NV = 10;
    localparam logic [31:0] TBL [NV] = '{
        {2'd2, 13'h0005, 8'hA5, 8'h00, 1'b0},  // R4
        {2'd1, 13'h0005, 8'h00, 8'hA5, 1'b0},  // R3
        {2'd2, 13'h0005, 8'h0F, 8'h00, 1'b1},  // R5
        {2'd1, 13'h0005, 8'h00, 8'hAF, 1'b0},  // R5 stored OR, R3 clears result
        {2'd2, 13'h0005, 8'hAF, 8'h00, 1'b0},  // R4 repeat program
        {2'd2, 13'h07FF, 8'h3C, 8'h00, 1'b0},  // R4 top address
        {2'd1, 13'h07FF, 8'h00, 8'h3C, 1'b0},  // R3
        {2'd1, 13'h0006, 8'h00, 8'h00, 1'b0},  // R3 blank byte
        {2'd2, 13'h0100, 8'h80, 8'h00, 1'b0},  // R2 high address bits
        {2'd1, 13'h0100, 8'h00, 8'h80, 1'b0}   // R2
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle(output int ones);
        logic [31:0] v;
        ones = 0;
        for (int k = 0; k < 200; k++) begin
            rd(8'h30, v);
            if (v[0] == 1'b0) break;
            ones++;
        end
    endtask

    task automatic run_op(input bit prog, input logic [12:0] a, input logic [7:0] d);
        int ones;
        wr(8'h04, {27'd0, a[12:8]});
        wr(8'h08, {24'd0, a[7:0]});
        wr(8'h10, {24'd0, d});
        wr(8'h14, 32'd1);
        wr(8'h20, prog ? 32'd2 : 32'd1);
        wr(8'h28, 32'd1);
        wait_idle(ones);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int ones;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); check("R1 power-down", v, 32'd1);
        rd(8'h30, v); check("R1 status", v, 32'd0);
        rd(8'h2C, v); check("R1 result", v, 32'd0);
        rd(8'h18, v); check("R1 read data", v, 32'd0);
        rd(8'h20, v); check("R1 function", v, 32'd0);
        rd(8'h28, v); check("R1 go", v, 32'd0);
        rd(8'h08, v); check("R1 addr low", v, 32'd0);

        // R6 go while powered down
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        rd(8'h30, v); check("R6 no busy", v, 32'd0);
        rd(8'h2C, v); check("R6 result", v, 32'd1);
        rd(8'h20, v); check("R10 function cleared on refusal", v, 32'd0);

        wr(8'h00, 32'd0);
        rd(8'h00, v); check("R1 power-down cleared", v, 32'd0);

        // R2 address split and masking
        wr(8'h04, 32'hFF); rd(8'h04, v); check("R2 addr high mask", v, 32'h1F);
        wr(8'h08, 32'h1AB); rd(8'h08, v); check("R2 addr low mask", v, 32'hAB);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            e = TBL[i];
            run_op(e[31:30] == 2'd2, e[29:17], e[16:9]);
            rd(8'h2C, v);
            check($sformatf("R3/R4/R5 result entry %0d", i), v, {31'd0, e[0]});
            if (e[31:30] == 2'd1) begin
                rd(8'h18, v);
                check($sformatf("R3 read byte entry %0d", i), v, {24'd0, e[8:1]});
            end
        end

        // R3 busy length, R10 go readback and self-clear
        wr(8'h04, 32'd0); wr(8'h08, 32'h05); wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        rd(8'h28, v); check("R10 go high while busy", v, 32'd1);
        wait_idle(ones);
        check("R3 busy length", ones + 1, BUSY);
        rd(8'h28, v); check("R10 go cleared", v, 32'd0);
        rd(8'h20, v); check("R10 function cleared", v, 32'd0);

        // R11 write during busy ignored
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        wr(8'h08, 32'h77);
        wait_idle(ones);
        rd(8'h08, v); check("R11 addr low unchanged", v, 32'h05);
        rd(8'h18, v); check("R11 read of original address", v, 32'hAF);

        // R7 program without byte mode
        wr(8'h08, 32'h10); wr(8'h10, 32'h55); wr(8'h14, 32'd0);
        wr(8'h20, 32'd2); wr(8'h28, 32'd1);
        rd(8'h30, v); check("R7 no busy", v, 32'd0);
        rd(8'h2C, v); check("R7 result", v, 32'd1);
        run_op(1'b0, 13'h010, 8'h00);
        rd(8'h18, v); check("R7 byte unchanged", v, 32'h00);

        // R8 bad function values
        wr(8'h20, 32'd3); wr(8'h28, 32'd1);
        rd(8'h30, v); check("R8 func 3 no busy", v, 32'd0);
        rd(8'h2C, v); check("R8 func 3 result", v, 32'd1);
        run_op(1'b0, 13'h010, 8'h00);
        wr(8'h20, 32'd0); wr(8'h28, 32'd1);
        rd(8'h2C, v); check("R8 func 0 result", v, 32'd1);

        // R9 address beyond storage
        run_op(1'b0, 13'h010, 8'h00);
        wr(8'h04, 32'h08); wr(8'h08, 32'h00); wr(8'h20, 32'd1); wr(8'h28, 32'd1);
        rd(8'h30, v); check("R9 no busy", v, 32'd0);
        rd(8'h2C, v); check("R9 result", v, 32'd1);

        // R12 go with bit 0 clear
        wr(8'h04, 32'h00);
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd2);
        rd(8'h30, v); check("R12 no busy", v, 32'd0);
        rd(8'h20, v); check("R12 function kept", v, 32'd1);
        rd(8'h2C, v); check("R12 result kept", v, 32'd1);

        // Teardown: power down again
        wr(8'h00, 32'd1);
        rd(8'h00, v); check("R1 power-down set", v, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule